// File: doc/BRIEF.md
# Serial Memory Read Engine

This block is the slave side of a small two-wire serial memory, covering only its read path. It watches the clock and data lines, recognises START and STOP, and compares the first byte after a START with its own select code. When that byte asks for a read, the block acknowledges and streams bytes from an internal byte array, MSB first. The data line is open-drain: the block only ever pulls it low through an enable output.

A 7-bit read pointer picks the byte that goes out next. The pointer keeps its value between transactions and steps by one after every byte sent. A master may read one byte and refuse it. It may instead acknowledge each byte to get a stream of consecutive locations, and the stream wraps from the top address back to zero. The pointer can be preset with a write-direction select followed by one address byte. A repeated START then turns that preset into a random read.

Bus lines are sampled on a system clock much faster than the bus clock. Storage sits outside the block behind a one-cycle synchronous read port.

Top module: `serial_mem_reader`

## Requirements
- R1: After reset the block does not drive the data line and issues no memory read. Until the first START it ignores all bus activity and acknowledges nothing.
- R2: The select code is sent MSB first as 1010, then the three chip-enable bits, then the direction bit (1 = read). On a match the block pulls the data line low for the whole ninth clock of that byte.
- R3: A select code whose type nibble or chip-enable bits differ is not acknowledged. The block leaves the data line alone until the next START.
- R4: In a read, the block sends the byte stored at the read pointer, MSB first. It changes the data line only while the bus clock is low.
- R5: The read pointer advances by exactly one after every byte sent, acknowledged or not. It holds its value across STOP and across later transactions.
- R6: When the master acknowledges a byte, the block goes on to send the byte at the next address.
- R7: After address 127 the pointer wraps to 0 and a stream continues from there.
- R8: If the data line is high during the ninth clock after a sent byte, the block stops driving. It stays idle until the next START, and the pointer does not move again.
- R9: A START seen at any point restarts select-code reception. A STOP seen at any point returns the block to idle.
- R10: A matching select with direction bit 0 is acknowledged. The low 7 bits of the byte that follows are loaded into the read pointer and acknowledged. Later bytes are ignored until a START.
- R11: The block releases the data line during the master's acknowledge bit after each byte it sends.
- R12: Each byte sent is fetched by exactly one single-cycle read strobe carrying the pointer as the address. The data is taken on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Bus clock line |
| sdaIn | input | 1 | Data line level as seen on the wire |
| sdaOe | output | 1 | 1 pulls the data line low, 0 releases it |
| chipSel | input | 3 | Chip-enable strap value compared with the select code |
| memAddr | output | 7 | Byte array read address |
| memRdEn | output | 1 | Byte array read strobe |
| memRdData | input | 8 | Byte array read data, valid the cycle after the strobe |

## Verification
On every cycle, the assertions check several bus rules. The pointer changes only when a byte ends or a preset address arrives, and then by exactly one or to the loaded value. START and STOP redirect the sequencer on the next cycle, and a refused byte or a wrong select code puts it back in idle. The data line drive changes only while the bus clock is low, and read strobes last one cycle. Only the bench scenarios can show the actual byte values coming out in order, including wrap-around from 127. They also show that the pointer persists across transactions and that nothing is driven after a mismatch or a refusal. The total of read strobes matching the bytes sent is also a bench-only result.

// File: rtl/smr_pkg.sv
package smr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ACKDEV,
    ST_ADDR,
    ST_ACKADDR,
    ST_TX,
    ST_MACK
  } smrState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic shiftIn;
    logic fetch;
    logic shiftTx;
    logic incAddr;
    logic loadAddr;
  } smrStrobe_t;

  // bus events from datapath to sequencer
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaLevel;
    logic sclLevel;
  } smrBusEv_t;

endpackage

// File: rtl/smr_datapath.sv
module smr_datapath
  import smr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sdaIn,
  input  smrStrobe_t        strobe,
  output smrBusEv_t         busEv,
  output logic [DATA_W-1:0] rxByte,
  output logic              txBit,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [DATA_W-1:0] memRdData
);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic                   sclPrev, sdaPrev;
  logic                   sclS, sdaS;
  logic [DATA_W-1:0]      rxShift, txShift;
  logic [ADDR_W-1:0]      addrCnt;
  logic                   fillPending;

  // line synchronisers, reset to the idle (high) level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], scl};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  assign busEv.sclRise   = sclS && !sclPrev;
  assign busEv.sclFall   = !sclS && sclPrev;
  assign busEv.startSeen = sclS && sclPrev && sdaPrev && !sdaS;
  assign busEv.stopSeen  = sclS && sclPrev && !sdaPrev && sdaS;
  assign busEv.sdaLevel  = sdaS;
  assign busEv.sclLevel  = sclS;

  // receive shifter, read pointer, transmit shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift     <= '0;
      txShift     <= '1;
      addrCnt     <= '0;
      fillPending <= 1'b0;
    end else begin
      if (strobe.shiftIn) rxShift <= {rxShift[DATA_W-2:0], sdaS};
      if (strobe.loadAddr) addrCnt <= rxShift[ADDR_W-1:0];
      else if (strobe.incAddr) addrCnt <= addrCnt + 1'b1;
      fillPending <= strobe.fetch;
      if (fillPending) txShift <= memRdData;
      else if (strobe.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b1};
    end
  end

  assign rxByte  = rxShift;
  assign txBit   = txShift[DATA_W-1];
  assign memAddr = addrCnt;
  assign memRdEn = strobe.fetch;

  // R5 / R7: pointer steps by one, modulo its width
  p_step_one_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incAddr && !strobe.loadAddr |=> addrCnt == ADDR_W'($past(addrCnt) + 1'b1));

  // R5: pointer holds without a strobe
  p_hold_ptr_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.incAddr && !strobe.loadAddr |=> $stable(addrCnt));

  // R10: preset address taken from received byte
  p_preset_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadAddr |=> addrCnt == $past(rxShift[ADDR_W-1:0]));

  // R12: read strobe lasts a single cycle
  p_fetch_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

endmodule

// File: rtl/smr_control.sv
module smr_control
  import smr_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          CHIP_W   = 3,
  parameter logic [3:0]  DEV_TYPE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  smrBusEv_t         busEv,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txBit,
  input  logic [CHIP_W-1:0] chipSel,
  output smrStrobe_t        strobe,
  output logic              sdaOe
);

  localparam int TYPE_W = DATA_W - 1 - CHIP_W;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  smrState_e        state, stNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic             byteDone, doneNext;
  logic             selMatch;

  assign selMatch = (rxByte[DATA_W-1 -: TYPE_W] == TYPE_W'(DEV_TYPE)) &&
                    (rxByte[CHIP_W:1] == chipSel);

  always_comb begin
    stNext   = state;
    cntNext  = bitCnt;
    doneNext = byteDone;
    strobe   = '0;
    if (busEv.startSeen) begin
      stNext   = ST_DEVSEL;
      cntNext  = '0;
      doneNext = 1'b0;
    end else if (busEv.stopSeen) begin
      stNext   = ST_IDLE;
      doneNext = 1'b0;
    end else begin
      case (state)
        ST_DEVSEL, ST_ADDR: begin
          if (busEv.sclRise && !byteDone) begin
            strobe.shiftIn = 1'b1;
            if (bitCnt == LAST_BIT) doneNext = 1'b1;
            else cntNext = bitCnt + 1'b1;
          end
          if (busEv.sclFall && byteDone) begin
            doneNext = 1'b0;
            cntNext  = '0;
            if (state == ST_ADDR) begin
              strobe.loadAddr = 1'b1;
              stNext = ST_ACKADDR;
            end else if (selMatch) begin
              strobe.fetch = rxByte[0];
              stNext = ST_ACKDEV;
            end else begin
              stNext = ST_IDLE;
            end
          end
        end
        ST_ACKDEV: if (busEv.sclFall) begin
          stNext  = rxByte[0] ? ST_TX : ST_ADDR;
          cntNext = '0;
        end
        ST_ACKADDR: if (busEv.sclFall) stNext = ST_IDLE;
        ST_TX: if (busEv.sclFall) begin
          if (bitCnt == LAST_BIT) begin
            strobe.incAddr = 1'b1;
            stNext = ST_MACK;
          end else begin
            strobe.shiftTx = 1'b1;
            cntNext = bitCnt + 1'b1;
          end
        end
        ST_MACK: begin
          if (busEv.sclRise) begin
            if (!busEv.sdaLevel) begin
              strobe.fetch = 1'b1;
              doneNext = 1'b1;
            end else begin
              stNext = ST_IDLE;
            end
          end
          if (busEv.sclFall && byteDone) begin
            stNext   = ST_TX;
            cntNext  = '0;
            doneNext = 1'b0;
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteDone <= 1'b0;
    end else begin
      state    <= stNext;
      bitCnt   <= cntNext;
      byteDone <= doneNext;
    end
  end

  assign sdaOe = (state == ST_ACKDEV) || (state == ST_ACKADDR) ||
                 ((state == ST_TX) && !txBit);

  // R9: START restarts select reception
  p_start_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    busEv.startSeen |=> state == ST_DEVSEL);

  // R9: STOP returns to idle
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    busEv.stopSeen |=> state == ST_IDLE && !sdaOe);

  // R8: refused byte ends the transfer
  p_nack_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_MACK && busEv.sclRise && busEv.sdaLevel && !busEv.startSeen && !busEv.stopSeen
    |=> state == ST_IDLE && !sdaOe);

  // R3: wrong select code leads to idle
  p_mismatch_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DEVSEL && busEv.sclFall && byteDone && !selMatch &&
    !busEv.startSeen && !busEv.stopSeen |=> state == ST_IDLE);

  // R4: drive changes only while the bus clock is low
  p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !busEv.sclLevel);

endmodule

// File: rtl/serial_mem_reader.sv
module serial_mem_reader
  import smr_pkg::*;
#(
  parameter int         ADDR_W   = 7,
  parameter int         DATA_W   = 8,
  parameter int         CHIP_W   = 3,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [CHIP_W-1:0] chipSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [DATA_W-1:0] memRdData
);

  smrStrobe_t        strobe;
  smrBusEv_t         busEv;
  logic [DATA_W-1:0] rxByte;
  logic              txBit;

  smr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(2)) uDatapath (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn), .strobe(strobe),
    .busEv(busEv), .rxByte(rxByte), .txBit(txBit), .memAddr(memAddr),
    .memRdEn(memRdEn), .memRdData(memRdData)
  );

  smr_control #(.DATA_W(DATA_W), .CHIP_W(CHIP_W), .DEV_TYPE(DEV_TYPE)) uControl (
    .clk(clk), .rstN(rstN), .busEv(busEv), .rxByte(rxByte), .txBit(txBit),
    .chipSel(chipSel), .strobe(strobe), .sdaOe(sdaOe)
  );

endmodule

// File: tb/tb_serial_mem_reader.sv
module tb_serial_mem_reader;

  localparam int HALF = 8;
  localparam logic [2:0] CHIP = 3'b101;
  localparam logic [7:0] SEL_RD = {4'b1010, CHIP, 1'b1};
  localparam logic [7:0] SEL_WR = {4'b1010, CHIP, 1'b0};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       mSda = 1'b1;
  logic       sdaOe;
  logic       sdaLine;
  logic [6:0] memAddr;
  logic       memRdEn;
  logic [7:0] memRdData = 8'h00;

  int   compared = 0;
  int   mismatched = 0;
  int   fetchCnt = 0;
  int   expFetch = 0;
  bit   pulseErr = 1'b0;
  bit   watchDrive = 1'b0;
  bit   driveSeen = 1'b0;
  bit   prevEn = 1'b0;
  bit   finished = 1'b0;
  logic [6:0] expCnt = 7'd0;

  always #10 clk = ~clk;

  assign sdaLine = mSda & ~sdaOe;

  serial_mem_reader dut (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .chipSel(CHIP), .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData)
  );

  function automatic logic [7:0] memf(input logic [6:0] a);
    return 8'({1'b0, a} * 8'd37 + 8'd11);
  endfunction

  // byte array model
  always @(posedge clk) if (memRdEn) memRdData <= memf(memAddr);

  // monitors
  always @(negedge clk) begin
    if (rstN) begin
      if (memRdEn) fetchCnt++;
      if (memRdEn && prevEn) pulseErr = 1'b1;
      prevEn = memRdEn;
      if (watchDrive && sdaOe) driveSeen = 1'b1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond;
    mSda = 1'b1; waitClk(HALF);
    scl = 1'b1;  waitClk(HALF);
    mSda = 1'b0; waitClk(HALF);
    scl = 1'b0;  waitClk(1);
  endtask

  task automatic stopCond;
    mSda = 1'b0; waitClk(HALF);
    scl = 1'b1;  waitClk(HALF);
    mSda = 1'b1; waitClk(HALF);
  endtask

  task automatic clockBit(input logic drv, output logic smp, output logic smpOe);
    mSda = drv;  waitClk(HALF);
    scl = 1'b1;  waitClk(HALF / 2);
    smp = sdaLine;
    smpOe = sdaOe;
    waitClk(HALF - HALF / 2);
    scl = 1'b0;  waitClk(1);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic s, o;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s, o);
    clockBit(1'b1, s, o);
    acked = ~s;
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] d, output logic oeAck);
    logic s, o;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s, o);
      d[i] = s;
    end
    clockBit(~mAck, s, o);
    oeAck = o;
  endtask

  task automatic testReset;
    chk("R1 reset drive", sdaOe, 0);
    chk("R1 reset strobe", memRdEn, 0);
  endtask

  task automatic testNoStart;
    logic a; logic [7:0] d; logic o;
    scl = 1'b0; waitClk(HALF);
    driveSeen = 1'b0; watchDrive = 1'b1;
    sendByte(SEL_RD, a);
    readByte(1'b0, d, o);
    watchDrive = 1'b0;
    chk("R1 no ack before START", a, 0);
    chk("R1 no data before START", d, 8'hFF);
    chk("R1 no drive before START", driveSeen, 0);
    chk("R1 no fetch before START", fetchCnt, 0);
  endtask

  task automatic preload(input logic [6:0] addr);
    logic a;
    startCond;
    sendByte(SEL_WR, a);
    chk("R2 write select ack", a, 1);
    sendByte({1'b0, addr}, a);
    chk("R10 address ack", a, 1);
    expCnt = addr;
  endtask

  task automatic readRun(input int n, input string req);
    logic a; logic [7:0] d; logic o;
    startCond;
    sendByte(SEL_RD, a);
    chk("R2 read select ack", a, 1);
    for (int k = 0; k < n; k++) begin
      readByte(k < n - 1, d, o);
      chk(req, d, memf(expCnt));
      chk("R11 released at master ack", o, 0);
      expCnt = expCnt + 7'd1;
      expFetch++;
    end
    stopCond;
  endtask

  task automatic testMismatch(input logic [7:0] sel, input string req);
    logic a; logic [7:0] d; logic o;
    startCond;
    driveSeen = 1'b0; watchDrive = 1'b1;
    sendByte(sel, a);
    readByte(1'b1, d, o);
    watchDrive = 1'b0;
    chk(req, a, 0);
    chk("R3 ignored data", d, 8'hFF);
    chk("R3 no drive after mismatch", driveSeen, 0);
    stopCond;
  endtask

  task automatic testNack;
    logic a; logic [7:0] d; logic o;
    startCond;
    sendByte(SEL_RD, a);
    chk("R8 select ack", a, 1);
    readByte(1'b0, d, o);
    chk("R8 byte before refusal", d, memf(expCnt));
    expCnt = expCnt + 7'd1;
    expFetch++;
    driveSeen = 1'b0; watchDrive = 1'b1;
    readByte(1'b1, d, o);
    watchDrive = 1'b0;
    chk("R8 idle after refusal", d, 8'hFF);
    chk("R8 no drive after refusal", driveSeen, 0);
    stopCond;
    readRun(1, "R8 pointer moved once");
  endtask

  task automatic testAbort;
    logic a, s, o; logic [7:0] d;
    startCond;
    for (int i = 7; i >= 4; i--) clockBit(SEL_WR[i] ^ 1'b1, s, o);
    startCond;
    sendByte(SEL_RD, a);
    chk("R9 START restarts select", a, 1);
    readByte(1'b0, d, o);
    chk("R9 data after restart", d, memf(expCnt));
    expCnt = expCnt + 7'd1;
    expFetch++;
    stopCond;
    startCond;
    for (int i = 7; i >= 4; i--) clockBit(SEL_RD[i], s, o);
    stopCond;
    scl = 1'b0; waitClk(HALF);
    sendByte(SEL_RD, a);
    chk("R9 STOP aborts select", a, 0);
    stopCond;
  endtask

  initial begin
    waitClk(5);
    testReset;
    rstN = 1'b1;
    waitClk(5);
    testReset;
    testNoStart;
    preload(7'h10);
    stopCond;
    readRun(1, "R4 current address byte");
    readRun(1, "R5 pointer persists");
    readRun(3, "R6 sequential byte");
    preload(7'h7E);
    readRun(4, "R7 wrap stream");
    testMismatch({4'b1010, 3'b010, 1'b1}, "R3 chip bits mismatch");
    testMismatch({4'b1011, CHIP, 1'b1}, "R3 type mismatch");
    testNack;
    testAbort;
    waitClk(4);
    chk("R12 one strobe per byte", fetchCnt, expFetch);
    chk("R12 strobe width", pulseErr, 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule